// File: doc/BRIEF.md
# Auxiliary Pin Function Multiplexer

This block drives a small bank of auxiliary output pins. Each pin takes its role from a 4-bit function code supplied by the configuration store. The roles are: a copy of a status signal (transmit-enable, power-enable, sleep), an activity indicator for a LED, a divided copy of the base clock, a bit-bang data or strobe line, or a fixed FIFO handshake role that depends on the pin position. Each pin decodes its own code and drives a value and an output-enable. A code that the pin cannot carry makes the pin drive high and raises that pin's configuration-error flag.

The block owns two timing resources that all pins share. One is a free-running 3-bit divider: its bits give the half, quarter and eighth rate clocks, so those clocks stay phase-aligned. The other is a pair of pulse stretchers that hold the transmit and receive LED indications for a programmable number of base-clock cycles after each activity pulse. This keeps a one-cycle burst visible. The status, FIFO and bit-bang sources come from the surrounding datapaths, and the function codes come from the configuration memory. None of these sources is part of this block.

Top module: `auxpin_mux`

## Requirements
- R1: While reset is held, both LED stretchers are idle and the divider count is zero. A pin coded for a divided clock (codes 0x7, 0x8, 0x9) reads 0, and a pin coded for a LED (codes 0x2, 0x3) reads 1.
- R2: The status codes drive a pin as follows. Code 0x0 gives `txden_i`. Code 0x1 gives the inverse of `pwr_ok_i` (active-low power-enable). Code 0x5 gives the inverse of `suspend_i` (active-low sleep).
- R3: Code 0x6 gives the base clock itself. Codes 0x7, 0x8 and 0x9 give bits 0, 1 and 2 of one 3-bit counter. The counter is cleared by reset and increments on every base-clock edge after reset, so every rising edge of the code 0x9 output coincides with falling edges of the code 0x7 and 0x8 outputs.
- R4: Code 0x3 gives the transmit LED and code 0x2 gives the receive LED, both active low. A LED is low in the cycle its activity input is high and for the following 2^LED_W - 1 cycles, which is 2^LED_W cycles in total. A new pulse restarts the count.
- R5: Code 0x4 is low whenever either the transmit or the receive LED indication is active.
- R6: On pins 0 to 3, code 0xA drives `bb_dout_i[p]` with output-enable `bb_oe_i[p]`. Code 0xB drives the inverse of `bb_wr_i`, and code 0xC drives the inverse of `bb_rd_i`.
- R7: On pins 0 to 3, code 0xD gives a fixed role per pin. Pin 0 gives the inverse of `fifo_rx_avail_i`, pin 1 the inverse of `fifo_tx_room_i`, pin 2 the inverse of `fifo_rd_i`, and pin 3 `fifo_wr_i`.
- R8: Codes 0xE and 0xF on any pin are illegal, and codes 0xA to 0xD on pin 4 are illegal. An illegal code drives the pin high with output-enable 1 and sets that pin's bit of `cfg_err_o`. A legal code clears the bit.
- R9: The output-enable of a pin is 1 for every code except 0xA.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Base clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pin_fn_i | input | NPINS*4 | Function code per pin, pin p at bits 4p+3..4p |
| txden_i | input | 1 | Transmit-enable status |
| pwr_ok_i | input | 1 | Powered and configured status |
| suspend_i | input | 1 | Suspend status |
| tx_act_i | input | 1 | Transmit activity pulse |
| rx_act_i | input | 1 | Receive activity pulse |
| fifo_rx_avail_i | input | 1 | FIFO has data for the host side to read |
| fifo_tx_room_i | input | 1 | FIFO can accept data |
| fifo_rd_i | input | 1 | FIFO read strobe |
| fifo_wr_i | input | 1 | FIFO write strobe |
| bb_dout_i | input | BB_PINS | Bit-bang output data |
| bb_oe_i | input | BB_PINS | Bit-bang direction, 1 = drive |
| bb_wr_i | input | 1 | Bit-bang write strobe |
| bb_rd_i | input | 1 | Bit-bang read strobe |
| pin_o | output | NPINS | Pin output values |
| pin_oe_o | output | NPINS | Pin output-enables |
| cfg_err_o | output | NPINS | Illegal-code flag per pin |

## Verification
Two things can happen in the same cycle. The first is an activity pulse on one LED channel while the other channel is still inside its hold window. The bench pulses receive activity part way through a transmit hold, and it pulses transmit again before its hold expires. It then checks the exact boundary cycles to confirm that the combined indicator stays low until the later expiry and that a retrigger restarts the count. The second is an illegal code on one pin in the same cycle as legal codes on its neighbours. Random code vectors place these side by side, and the bench checks that only the offending pin's flag rises while the others keep their normal values.

// File: rtl/auxpin_pkg.sv
package auxpin_pkg;

  localparam int AUX_BB_PINS = 4;

  typedef enum logic [3:0] {
    FN_TXDEN    = 4'h0,
    FN_PWREN_N  = 4'h1,
    FN_RXLED_N  = 4'h2,
    FN_TXLED_N  = 4'h3,
    FN_ANYLED_N = 4'h4,
    FN_SLEEP_N  = 4'h5,
    FN_CLK_D1   = 4'h6,
    FN_CLK_D2   = 4'h7,
    FN_CLK_D4   = 4'h8,
    FN_CLK_D8   = 4'h9,
    FN_BB_IO    = 4'hA,
    FN_BB_WR_N  = 4'hB,
    FN_BB_RD_N  = 4'hC,
    FN_HSHK     = 4'hD
  } pin_fn_e;

  typedef struct packed {
    logic       clk_base;
    logic [2:0] div;
    logic       txden;
    logic       pwr_ok;
    logic       suspend;
    logic       tx_led;
    logic       rx_led;
    logic       rx_avail;
    logic       tx_room;
    logic       fifo_rd;
    logic       fifo_wr;
    logic       bb_wr;
    logic       bb_rd;
  } pin_src_t;

  typedef struct packed {
    logic err;
    logic oe;
    logic val;
  } pin_drv_t;

  function automatic logic fn_legal(int pin, logic [3:0] code);
    if (code <= 4'h9) return 1'b1;
    if (code <= 4'hD) return (pin < AUX_BB_PINS);
    return 1'b0;
  endfunction

  function automatic logic hshk_role(int pin, pin_src_t s);
    case (pin)
      0:       return ~s.rx_avail;
      1:       return ~s.tx_room;
      2:       return ~s.fifo_rd;
      3:       return s.fifo_wr;
      default: return 1'b1;
    endcase
  endfunction

  function automatic pin_drv_t pin_drive(int pin, logic [3:0] code, pin_src_t s,
                                         logic bb_d, logic bb_oe);
    pin_drv_t r;
    r.err = 1'b0;
    r.oe  = 1'b1;
    r.val = 1'b1;
    if (!fn_legal(pin, code)) begin
      r.err = 1'b1;
    end else begin
      case (pin_fn_e'(code))
        FN_TXDEN:    r.val = s.txden;
        FN_PWREN_N:  r.val = ~s.pwr_ok;
        FN_RXLED_N:  r.val = ~s.rx_led;
        FN_TXLED_N:  r.val = ~s.tx_led;
        FN_ANYLED_N: r.val = ~(s.tx_led | s.rx_led);
        FN_SLEEP_N:  r.val = ~s.suspend;
        FN_CLK_D1:   r.val = s.clk_base;
        FN_CLK_D2:   r.val = s.div[0];
        FN_CLK_D4:   r.val = s.div[1];
        FN_CLK_D8:   r.val = s.div[2];
        FN_BB_IO: begin
          r.val = bb_d;
          r.oe  = bb_oe;
        end
        FN_BB_WR_N:  r.val = ~s.bb_wr;
        FN_BB_RD_N:  r.val = ~s.bb_rd;
        FN_HSHK:     r.val = hshk_role(pin, s);
        default:     r.val = 1'b1;
      endcase
    end
    return r;
  endfunction

endpackage

// File: rtl/auxpin_clkdiv.sv
module auxpin_clkdiv #(
  parameter int DIV_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  output logic [DIV_W-1:0] div_o
);

  logic [DIV_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_q + 1'b1;
  end

  assign div_o = cnt_q;

  // top divided clock rises only together with falls of the faster ones
  assert_phase_align_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(div_o[DIV_W-1]) |-> ($fell(div_o[0]) && $fell(div_o[1])));

endmodule

// File: rtl/auxpin_led_stretch.sv
module auxpin_led_stretch #(
  parameter int HOLD_W = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic act_i,
  output logic led_on_o
);

  localparam logic [HOLD_W-1:0] HOLD_LOAD = '1;

  logic [HOLD_W-1:0] cnt_q;
  logic              busy;

  always_ff @(posedge clk) begin
    if (!rst_n)        cnt_q <= '0;
    else if (act_i)    cnt_q <= HOLD_LOAD;
    else if (busy)     cnt_q <= cnt_q - 1'b1;
  end

  assign busy     = (cnt_q != '0);
  assign led_on_o = act_i | busy;

  assert_hold_after_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
    act_i |=> led_on_o);

  assert_no_early_release_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(led_on_o) && $past(rst_n)) |-> !$past(act_i));

endmodule

// File: rtl/auxpin_pin_sel.sv
module auxpin_pin_sel
  import auxpin_pkg::*;
#(
  parameter int PIN_IDX = 0
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [3:0] code_i,
  input  pin_src_t   src_i,
  input  logic       bb_d_i,
  input  logic       bb_oe_i,
  output logic       pin_o,
  output logic       oe_o,
  output logic       err_o
);

  pin_drv_t drv;

  always_comb drv = pin_drive(PIN_IDX, code_i, src_i, bb_d_i, bb_oe_i);

  assign pin_o = drv.val;
  assign oe_o  = drv.oe;
  assign err_o = drv.err;

  assert_err_drives_high_R8: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |-> (pin_o && oe_o));

  assert_oe_only_io_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (code_i != FN_BB_IO) |-> oe_o);

endmodule

// File: rtl/auxpin_mux.sv
module auxpin_mux
  import auxpin_pkg::*;
#(
  parameter int NPINS = 5,
  parameter int LED_W = 16,
  localparam int BB_PINS = (NPINS < AUX_BB_PINS) ? NPINS : AUX_BB_PINS
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NPINS*4-1:0] pin_fn_i,
  input  logic               txden_i,
  input  logic               pwr_ok_i,
  input  logic               suspend_i,
  input  logic               tx_act_i,
  input  logic               rx_act_i,
  input  logic               fifo_rx_avail_i,
  input  logic               fifo_tx_room_i,
  input  logic               fifo_rd_i,
  input  logic               fifo_wr_i,
  input  logic [BB_PINS-1:0] bb_dout_i,
  input  logic [BB_PINS-1:0] bb_oe_i,
  input  logic               bb_wr_i,
  input  logic               bb_rd_i,
  output logic [NPINS-1:0]   pin_o,
  output logic [NPINS-1:0]   pin_oe_o,
  output logic [NPINS-1:0]   cfg_err_o
);

  localparam int DIV_W = 3;

  logic [DIV_W-1:0] div;
  logic             tx_led_on;
  logic             rx_led_on;
  pin_src_t         src;

  auxpin_clkdiv #(.DIV_W(DIV_W)) u_div (
    .clk   (clk),
    .rst_n (rst_n),
    .div_o (div)
  );

  auxpin_led_stretch #(.HOLD_W(LED_W)) u_tx_led (
    .clk      (clk),
    .rst_n    (rst_n),
    .act_i    (tx_act_i),
    .led_on_o (tx_led_on)
  );

  auxpin_led_stretch #(.HOLD_W(LED_W)) u_rx_led (
    .clk      (clk),
    .rst_n    (rst_n),
    .act_i    (rx_act_i),
    .led_on_o (rx_led_on)
  );

  always_comb begin
    src.clk_base = clk;
    src.div      = div;
    src.txden    = txden_i;
    src.pwr_ok   = pwr_ok_i;
    src.suspend  = suspend_i;
    src.tx_led   = tx_led_on;
    src.rx_led   = rx_led_on;
    src.rx_avail = fifo_rx_avail_i;
    src.tx_room  = fifo_tx_room_i;
    src.fifo_rd  = fifo_rd_i;
    src.fifo_wr  = fifo_wr_i;
    src.bb_wr    = bb_wr_i;
    src.bb_rd    = bb_rd_i;
  end

  for (genvar p = 0; p < NPINS; p++) begin : g_pin
    logic bd;
    logic bo;

    if (p < BB_PINS) begin : g_bb
      assign bd = bb_dout_i[p];
      assign bo = bb_oe_i[p];
    end else begin : g_nobb
      assign bd = 1'b0;
      assign bo = 1'b0;

      assert_upper_err_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_fn_i[p*4 +: 4] >= 4'hA) |-> cfg_err_o[p]);
    end

    auxpin_pin_sel #(.PIN_IDX(p)) u_sel (
      .clk     (clk),
      .rst_n   (rst_n),
      .code_i  (pin_fn_i[p*4 +: 4]),
      .src_i   (src),
      .bb_d_i  (bd),
      .bb_oe_i (bo),
      .pin_o   (pin_o[p]),
      .oe_o    (pin_oe_o[p]),
      .err_o   (cfg_err_o[p])
    );
  end

  assert_combined_led_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_led_on || rx_led_on) |-> !(pin_fn_i[3:0] == 4'h4 && pin_o[0]));

endmodule

// File: tb/auxpin_mux_tb.sv
module auxpin_mux_tb_top;

  localparam int NP = 5;
  localparam int LW = 8;
  localparam int HOLD = 1 << LW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NP*4-1:0] fn = '0;
  logic txden = 0, pwr = 0, susp = 0, txa = 0, rxa = 0;
  logic rxav = 0, txrm = 0, frd = 0, fwr = 0, bbwr = 0, bbrd = 0;
  logic [3:0] bbd = '0, bbo = '0;
  logic [NP-1:0] pin, oe, err;
  logic [31:0] ecount = '0;
  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  always @(posedge clk) begin
    if (!rst_n) ecount <= '0;
    else        ecount <= ecount + 1;
  end

  auxpin_mux #(.NPINS(NP), .LED_W(LW)) dut_i (
    .clk(clk), .rst_n(rst_n), .pin_fn_i(fn),
    .txden_i(txden), .pwr_ok_i(pwr), .suspend_i(susp),
    .tx_act_i(txa), .rx_act_i(rxa),
    .fifo_rx_avail_i(rxav), .fifo_tx_room_i(txrm),
    .fifo_rd_i(frd), .fifo_wr_i(fwr),
    .bb_dout_i(bbd), .bb_oe_i(bbo), .bb_wr_i(bbwr), .bb_rd_i(bbrd),
    .pin_o(pin), .pin_oe_o(oe), .cfg_err_o(err)
  );

  task automatic finish_run();
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  task automatic chk(string req, int p, logic [2:0] got, logic [2:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s pin%0d: got err/oe/val=%b expected %b", req, p, got, exp);
    end
  endtask

  function automatic logic [2:0] model(int p, logic [3:0] c, logic txl, logic rxl);
    if (c >= 4'hE || (p >= 4 && c >= 4'hA)) return 3'b111;
    case (c)
      4'h0: return {2'b01, txden};
      4'h1: return {2'b01, !pwr};
      4'h2: return {2'b01, !rxl};
      4'h3: return {2'b01, !txl};
      4'h4: return {2'b01, !(txl || rxl)};
      4'h5: return {2'b01, !susp};
      4'h6: return 3'b011;
      4'h7: return {2'b01, ecount[0]};
      4'h8: return {2'b01, ecount[1]};
      4'h9: return {2'b01, ecount[2]};
      4'hA: return {1'b0, bbo[p], bbd[p]};
      4'hB: return {2'b01, !bbwr};
      4'hC: return {2'b01, !bbrd};
      default: begin
        if (p == 0) return {2'b01, !rxav};
        if (p == 1) return {2'b01, !txrm};
        if (p == 2) return {2'b01, !frd};
        return {2'b01, fwr};
      end
    endcase
  endfunction

  function automatic string req_of(int p, logic [3:0] c);
    if (c >= 4'hE || (p >= 4 && c >= 4'hA)) return "R8";
    if (c == 4'h0 || c == 4'h1 || c == 4'h5) return "R2";
    if (c == 4'h2 || c == 4'h3) return "R4";
    if (c == 4'h4) return "R5";
    if (c <= 4'h9) return "R3";
    if (c == 4'hA) return "R6/R9";
    if (c <= 4'hC) return "R6";
    return "R7";
  endfunction

  task automatic check_all(logic txl, logic rxl);
    for (int p = 0; p < NP; p++)
      chk(req_of(p, fn[p*4 +: 4]), p, {err[p], oe[p], pin[p]},
          model(p, fn[p*4 +: 4], txl, rxl));
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic wait_edges(int k);
    repeat (k) @(posedge clk);
    #3;
  endtask

  task automatic pulse(bit is_tx);
    step();
    if (is_tx) txa = 1'b1; else rxa = 1'b1;
    step();
    if (is_tx) txa = 1'b0; else rxa = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    void'($urandom(32'h5EED_0A17));
    // R1: reset state, divided clocks on pins 0..2, LEDs on pins 3..4
    fn = {4'h3, 4'h2, 4'h9, 4'h8, 4'h7};
    repeat (3) @(posedge clk);
    #3;
    chk("R1", 0, {err[0], oe[0], pin[0]}, 3'b010);
    chk("R1", 1, {err[1], oe[1], pin[1]}, 3'b010);
    chk("R1", 2, {err[2], oe[2], pin[2]}, 3'b010);
    chk("R1", 3, {err[3], oe[3], pin[3]}, 3'b011);
    chk("R1", 4, {err[4], oe[4], pin[4]}, 3'b011);
    step();
    rst_n = 1'b1;

    // R3: divider sequence over several edges
    for (int i = 0; i < 10; i++) begin
      step();
      #2;
      check_all(1'b0, 1'b0);
    end

    // R2: status codes, both polarities
    step();
    fn = {4'h5, 4'h1, 4'h0, 4'h1, 4'h0};
    txden = 1; pwr = 1; susp = 0;
    #2; check_all(1'b0, 1'b0);
    step();
    txden = 0; pwr = 0; susp = 1;
    #2; check_all(1'b0, 1'b0);

    // R7: handshake roles
    step();
    fn = {4'h0, 4'hD, 4'hD, 4'hD, 4'hD};
    rxav = 1; txrm = 0; frd = 1; fwr = 0;
    #2; check_all(1'b0, 1'b0);
    step();
    rxav = 0; txrm = 1; frd = 0; fwr = 1;
    #2; check_all(1'b0, 1'b0);

    // R9 and R6: bit-bang I/O tristate, strobes
    step();
    fn = {4'h0, 4'hC, 4'hB, 4'hA, 4'hA};
    bbd = 4'b0011; bbo = 4'b0010; bbwr = 1; bbrd = 0;
    #2;
    chk("R9", 0, {err[0], oe[0], pin[0]}, 3'b001);
    chk("R9", 1, {err[1], oe[1], pin[1]}, 3'b011);
    check_all(1'b0, 1'b0);

    // R8: illegal codes next to legal ones
    step();
    fn = {4'hD, 4'h0, 4'hE, 4'hF, 4'h5};
    #2; check_all(1'b0, 1'b0);
    step();
    fn = {4'hA, 4'hC, 4'h9, 4'h0, 4'hE};
    #2; check_all(1'b0, 1'b0);

    // R4/R5: tx pulse, then rx pulse inside the tx hold
    step();
    fn = {4'h0, 4'h0, 4'h4, 4'h2, 4'h3};
    pulse(1'b1);
    #2;
    chk("R4", 0, {err[0], oe[0], pin[0]}, 3'b010);
    wait_edges(99);
    pulse(1'b0);
    wait_edges(HOLD - 103);
    chk("R4", 0, {err[0], oe[0], pin[0]}, 3'b010);
    wait_edges(1);
    chk("R4", 0, {err[0], oe[0], pin[0]}, 3'b011);
    chk("R5", 2, {err[2], oe[2], pin[2]}, 3'b010);
    chk("R4", 1, {err[1], oe[1], pin[1]}, 3'b010);
    wait_edges(100);
    chk("R4", 1, {err[1], oe[1], pin[1]}, 3'b010);
    chk("R5", 2, {err[2], oe[2], pin[2]}, 3'b010);
    wait_edges(1);
    chk("R4", 1, {err[1], oe[1], pin[1]}, 3'b011);
    chk("R5", 2, {err[2], oe[2], pin[2]}, 3'b011);

    // R4: retrigger restarts the hold
    pulse(1'b1);
    wait_edges(48);
    pulse(1'b1);
    wait_edges(HOLD - 2);
    chk("R4", 0, {err[0], oe[0], pin[0]}, 3'b010);
    wait_edges(1);
    chk("R4", 0, {err[0], oe[0], pin[0]}, 3'b011);

    // random codes and inputs, LEDs idle
    for (int i = 0; i < 400; i++) begin
      step();
      fn = NP * 4'($urandom);
      fn = 20'($urandom);
      {txden, pwr, susp, rxav, txrm, frd, fwr, bbwr, bbrd} = 9'($urandom);
      bbd = 4'($urandom);
      bbo = 4'($urandom);
      #2;
      check_all(1'b0, 1'b0);
    end

    finish_run();
  end

endmodule